// File: doc/BRIEF.md
# Handshake converter for a wide-write, narrow-read bus transfer

This block sits between a two-requester bus arbiter, a slave that writes one 32-bit word per access, a consumer master that reads 16 bits at a time, and the outside environment. It sees every control signal these parties exchange and decides, cycle by cycle, what each receiver gets. Requester-1 traffic (request, ready and its grant) belongs to the environment. The converter cannot hold it back, so it passes straight through in the same cycle. The requester-2 handshake (request, grant, select, ready) is caught in one-bit holding flags and released only when the transfer sequence allows it. The master needs a "keep reading" strobe that no other party drives, so the converter creates it.

A state machine runs one transfer at a time. ST_IDLE waits for a held request and moves to ST_ASK. ST_ASK shows that request to the arbiter until the arbiter grants requester 2, then moves to ST_GRANT. ST_GRANT passes a single grant pulse to the master and moves to ST_SELECT when the master asserts its select. ST_SELECT passes the select to the slave if the channel has room for a full word, then moves to ST_WRITE. ST_WRITE waits for the slave's write strobe and moves to ST_DRAIN. ST_DRAIN issues the generated strobe for exactly word/read-width cycles and stays until the channel count is back to zero, then moves to ST_RELEASE. ST_RELEASE hands the held slave-ready to the arbiter and returns to ST_IDLE. A fill counter tracks the bits present in the channel, so the arbiter cannot close the transfer while the master is still reading.

Top module: `xfer_converter`

## Requirements
- R1: In the same cycle, arb_req1 equals env_req1, arb_rdy1 equals env_rdy1, and env_gnt1 equals arb_gnt1.
- R2: While rst is high at a clock edge, the machine returns to ST_IDLE, all holding flags clear and the fill count clears. After reset, every converter output that does not come from R1 is low, and a request captured before reset is never forwarded.
- R3: Each held signal is one flag. Several captures before its release, or a grant the arbiter holds for many cycles, give exactly one forwarded pulse.
- R4: A held signal reaches its receiver only while its flag is set. arb_req2 first rises two cycles after mst_req2 is first sampled high in ST_IDLE.
- R5: arb_req2 stays high while the arbiter serves requester 1. mst_gnt2 pulses for one cycle, in the cycle after arb_gnt2 is first high.
- R6: slv_selr is high for one cycle, in the cycle after the master's mst_selr is sampled in ST_GRANT.
- R7: mst_more is high for exactly WR_BITS/RD_BITS consecutive cycles, starting the cycle after the slave's write strobe. chan_fill steps 32, 16, 0 as the master's reads land.
- R8: arb_rdy2 stays low until chan_fill is 0 and mst_more has ended. A slave ready that arrives earlier is held until then. One that arrives in ST_RELEASE is forwarded in the next cycle.
- R9: A write strobe outside ST_WRITE, or one that would push chan_fill above CAP_BITS, is ignored. A read strobe while chan_fill is below RD_BITS is ignored. slv_selr is withheld while a full word would not fit.
- R10: After arb_rdy2 is released, the machine is back in ST_IDLE, and a new request starts the same sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| env_req1 | input | 1 | Requester-1 request from the environment |
| env_rdy1 | input | 1 | Requester-1 transfer done from the environment |
| arb_gnt1 | input | 1 | Requester-1 grant from the arbiter |
| arb_gnt2 | input | 1 | Requester-2 grant from the arbiter |
| mst_req2 | input | 1 | Bus request from the consumer master |
| mst_selr | input | 1 | Read select from the consumer master |
| slv_wrt | input | 1 | Slave places a full word on the channel |
| slv_rdy2 | input | 1 | Slave transfer-done indication |
| mst_rd | input | 1 | Master takes one narrow read from the channel |
| arb_req1 | output | 1 | Relayed requester-1 request to the arbiter |
| arb_rdy1 | output | 1 | Relayed requester-1 done to the arbiter |
| env_gnt1 | output | 1 | Relayed requester-1 grant to the environment |
| arb_req2 | output | 1 | Forwarded master request to the arbiter |
| mst_gnt2 | output | 1 | Forwarded grant to the master |
| slv_selr | output | 1 | Forwarded read select to the slave |
| arb_rdy2 | output | 1 | Forwarded transfer-done to the arbiter |
| mst_more | output | 1 | Generated keep-reading strobe to the master |
| chan_fill | output | FILL_W | Bits currently in the channel |

## Verification
The transfer runs under three patterns. In the plain pattern the arbiter grants at once and the slave reports done together with its write. In the contested pattern requester 1 holds the arbiter for a while, which separates a request that persists from one forwarded only once. In the late pattern the slave reports done only after draining, which separates a ready that is held until reads finish from one that is forwarded as it arrives. The plain pattern also repeats the ready and the write strobe, so double counting or an overflow shows up. A stray read in idle and a reset that lands while a request is held close out the boundary cases.

// File: rtl/xconv_pkg.sv
package xconv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_GRANT,
        ST_SELECT,
        ST_WRITE,
        ST_DRAIN,
        ST_RELEASE
    } conv_state_e;

    // Holding-flag slots for the delayed handshake signals
    localparam int NSIG  = 4;
    localparam int B_REQ = 0;
    localparam int B_GNT = 1;
    localparam int B_SEL = 2;
    localparam int B_RDY = 3;

endpackage

// File: rtl/xconv_relay.sv
module xconv_relay #(
    parameter int N = 3
) (
    input  logic [N-1:0] in_i,
    output logic [N-1:0] out_o
);
    // Zero-delay pass-through for signals the converter may not hold back
    for (genvar i = 0; i < N; i++) begin : g_wire
        assign out_o[i] = in_i[i];
    end
endmodule

// File: rtl/xconv_flagbuf.sv
module xconv_flagbuf #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cap_i,
    input  logic [N-1:0] emit_req_i,
    output logic [N-1:0] held_o,
    output logic [N-1:0] emit_o
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic held_q;

        // A slot can only release what it holds
        assign emit_o[i] = emit_req_i[i] & held_q;
        assign held_o[i] = held_q;

        // next = (held minus released) plus captured
        always_ff @(posedge clk) begin
            if (rst) held_q <= 1'b0;
            else     held_q <= (held_q & ~emit_o[i]) | cap_i[i];
        end
    end
endmodule

// File: rtl/xconv_chan.sv
module xconv_chan #(
    parameter int WR_BITS  = 32,
    parameter int RD_BITS  = 16,
    parameter int CAP_BITS = 32,
    parameter int FILL_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [FILL_W-1:0] fill_o,
    output logic              room_o,
    output logic              empty_o
);
    localparam logic [FILL_W:0] WR_X  = (FILL_W+1)'(WR_BITS);
    localparam logic [FILL_W:0] RD_X  = (FILL_W+1)'(RD_BITS);
    localparam logic [FILL_W:0] CAP_X = (FILL_W+1)'(CAP_BITS);

    logic [FILL_W-1:0] fill_q;
    logic [FILL_W:0]   fill_x;
    logic [FILL_W:0]   fill_n;
    logic              wr_ok;
    logic              rd_ok;

    assign fill_x  = {1'b0, fill_q};
    assign room_o  = (fill_x + WR_X) <= CAP_X;
    assign empty_o = (fill_q == '0);
    assign wr_ok   = wr_i & room_o;
    assign rd_ok   = rd_i & (fill_x >= RD_X);
    assign fill_o  = fill_q;

    always_comb begin
        fill_n = fill_x;
        if (wr_ok) fill_n = fill_n + WR_X;
        if (rd_ok) fill_n = fill_n - RD_X;
    end

    always_ff @(posedge clk) begin
        if (rst) fill_q <= '0;
        else     fill_q <= fill_n[FILL_W-1:0];
    end
endmodule

// File: rtl/xconv_seq.sv
module xconv_seq
    import xconv_pkg::*;
#(
    parameter int NRD   = 2,
    parameter int CNT_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSIG-1:0] held_i,
    input  logic            arb_gnt2_i,
    input  logic            mst_selr_i,
    input  logic            slv_wrt_i,
    input  logic            room_i,
    input  logic            empty_i,
    output logic [NSIG-1:0] cap_en_o,
    output logic [NSIG-1:0] emit_req_o,
    output logic            more_o,
    output logic            wr_en_o
);
    localparam logic [CNT_W-1:0] NRD_C = CNT_W'(NRD);

    conv_state_e      state_q, state_n;
    logic [CNT_W-1:0] issued_q;

    // State register and generated-strobe counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            issued_q <= '0;
        end else begin
            state_q <= state_n;
            if (state_q != ST_DRAIN) issued_q <= '0;
            else if (more_o)         issued_q <= issued_q + 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n    = state_q;
        cap_en_o   = '0;
        emit_req_o = '0;
        more_o     = 1'b0;
        wr_en_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cap_en_o[B_REQ] = 1'b1;
                if (held_i[B_REQ]) state_n = ST_ASK;
            end
            ST_ASK: begin
                emit_req_o[B_REQ] = 1'b1;
                cap_en_o[B_REQ]   = ~arb_gnt2_i;
                cap_en_o[B_GNT]   = 1'b1;
                if (arb_gnt2_i) state_n = ST_GRANT;
            end
            ST_GRANT: begin
                emit_req_o[B_GNT] = 1'b1;
                cap_en_o[B_SEL]   = 1'b1;
                if (mst_selr_i) state_n = ST_SELECT;
            end
            ST_SELECT: begin
                emit_req_o[B_SEL] = room_i;
                if (held_i[B_SEL] && room_i) state_n = ST_WRITE;
            end
            ST_WRITE: begin
                cap_en_o[B_RDY] = 1'b1;
                wr_en_o         = slv_wrt_i;
                if (slv_wrt_i) state_n = ST_DRAIN;
            end
            ST_DRAIN: begin
                cap_en_o[B_RDY] = 1'b1;
                more_o          = (issued_q < NRD_C);
                if ((issued_q == NRD_C) && empty_i) state_n = ST_RELEASE;
            end
            ST_RELEASE: begin
                cap_en_o[B_RDY]   = 1'b1;
                emit_req_o[B_RDY] = 1'b1;
                if (held_i[B_RDY]) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/xfer_converter.sv
module xfer_converter
    import xconv_pkg::*;
#(
    parameter int WR_BITS  = 32,
    parameter int RD_BITS  = 16,
    parameter int CAP_BITS = 32,
    parameter int FILL_W   = $clog2(CAP_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              env_req1,
    input  logic              env_rdy1,
    input  logic              arb_gnt1,
    input  logic              arb_gnt2,
    input  logic              mst_req2,
    input  logic              mst_selr,
    input  logic              slv_wrt,
    input  logic              slv_rdy2,
    input  logic              mst_rd,
    output logic              arb_req1,
    output logic              arb_rdy1,
    output logic              env_gnt1,
    output logic              arb_req2,
    output logic              mst_gnt2,
    output logic              slv_selr,
    output logic              arb_rdy2,
    output logic              mst_more,
    output logic [FILL_W-1:0] chan_fill
);
    localparam int NRD   = WR_BITS / RD_BITS;
    localparam int CNT_W = $clog2(NRD + 1);

    logic [NSIG-1:0] sig_in, cap_en, cap, emit_req, emit, held;
    logic            room, empty, wr_en;

    xconv_relay #(.N(3)) u_relay (
        .in_i  ({arb_gnt1, env_rdy1, env_req1}),
        .out_o ({env_gnt1, arb_rdy1, arb_req1})
    );

    assign sig_in[B_REQ] = mst_req2;
    assign sig_in[B_GNT] = arb_gnt2;
    assign sig_in[B_SEL] = mst_selr;
    assign sig_in[B_RDY] = slv_rdy2;
    assign cap           = sig_in & cap_en;

    xconv_flagbuf #(.N(NSIG)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .cap_i      (cap),
        .emit_req_i (emit_req),
        .held_o     (held),
        .emit_o     (emit)
    );

    xconv_chan #(
        .WR_BITS (WR_BITS), .RD_BITS (RD_BITS),
        .CAP_BITS(CAP_BITS), .FILL_W (FILL_W)
    ) u_chan (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_en),
        .rd_i    (mst_rd),
        .fill_o  (chan_fill),
        .room_o  (room),
        .empty_o (empty)
    );

    xconv_seq #(.NRD(NRD), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .held_i     (held),
        .arb_gnt2_i (arb_gnt2),
        .mst_selr_i (mst_selr),
        .slv_wrt_i  (slv_wrt),
        .room_i     (room),
        .empty_i    (empty),
        .cap_en_o   (cap_en),
        .emit_req_o (emit_req),
        .more_o     (mst_more),
        .wr_en_o    (wr_en)
    );

    assign arb_req2 = emit[B_REQ];
    assign mst_gnt2 = emit[B_GNT];
    assign slv_selr = emit[B_SEL];
    assign arb_rdy2 = emit[B_RDY];
endmodule

// File: rtl/xfer_converter_chk.sv
module xfer_converter_chk #(
    parameter int CAP_BITS = 32,
    parameter int NRD      = 2,
    parameter int FILL_W   = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              arb_gnt2,
    input logic              mst_gnt2,
    input logic              slv_selr,
    input logic              arb_rdy2,
    input logic              mst_more,
    input logic [FILL_W-1:0] chan_fill
);
    int more_run;

    always_ff @(posedge clk) begin
        if (rst)           more_run <= 0;
        else if (mst_more) more_run <= more_run + 1;
        else               more_run <= 0;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        int'(chan_fill) <= CAP_BITS);

    assert_grant_single_R3: assert property (@(posedge clk) disable iff (rst)
        mst_gnt2 |=> !mst_gnt2);

    assert_grant_after_arb_R5: assert property (@(posedge clk) disable iff (rst)
        mst_gnt2 |-> $past(arb_gnt2));

    assert_more_length_R7: assert property (@(posedge clk) disable iff (rst)
        mst_more |-> (more_run < NRD));

    assert_ready_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        arb_rdy2 |-> (chan_fill == '0 && !mst_more));

    assert_select_not_during_drain_R6: assert property (@(posedge clk) disable iff (rst)
        slv_selr |-> !mst_more);
endmodule

bind xfer_converter xfer_converter_chk #(
    .CAP_BITS (CAP_BITS),
    .NRD      (WR_BITS / RD_BITS),
    .FILL_W   (FILL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arb_gnt2  (arb_gnt2),
    .mst_gnt2  (mst_gnt2),
    .slv_selr  (slv_selr),
    .arb_rdy2  (arb_rdy2),
    .mst_more  (mst_more),
    .chan_fill (chan_fill)
);

// File: tb/xfer_converter_bench.sv
`timescale 1ns/1ps
module xfer_converter_bench;
    localparam int EV_GNT = 0, EV_SEL = 1, EV_MORE = 2, EV_RDY = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic env_req1 = 0, env_rdy1 = 0, arb_gnt1 = 0, arb_gnt2 = 0;
    logic mst_req2 = 0, mst_selr = 0, slv_wrt = 0, slv_rdy2 = 0;
    logic rd_model = 0, rd_force = 0, more_seen = 0;
    logic mst_rd;
    logic arb_req1, arb_rdy1, env_gnt1, arb_req2, mst_gnt2, slv_selr, arb_rdy2, mst_more;
    logic [5:0] chan_fill;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit finished = 0;

    assign mst_rd = rd_model | rd_force;

    always #10 clk = ~clk;

    xfer_converter u_xfer_converter (
        .clk(clk), .rst(rst),
        .env_req1(env_req1), .env_rdy1(env_rdy1), .arb_gnt1(arb_gnt1), .arb_gnt2(arb_gnt2),
        .mst_req2(mst_req2), .mst_selr(mst_selr), .slv_wrt(slv_wrt), .slv_rdy2(slv_rdy2),
        .mst_rd(mst_rd),
        .arb_req1(arb_req1), .arb_rdy1(arb_rdy1), .env_gnt1(env_gnt1), .arb_req2(arb_req2),
        .mst_gnt2(mst_gnt2), .slv_selr(slv_selr), .arb_rdy2(arb_rdy2), .mst_more(mst_more),
        .chan_fill(chan_fill)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic settle();
        #1;
    endtask

    // Monitor: pops the expected handshake events as they appear
    task automatic observe(input int ev);
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3 unexpected event actual=%0d expected=none", ev);
        end else begin
            int e = exp_q.pop_front();
            if (e != ev) begin
                errors++;
                $display("FAIL R6 event order actual=%0d expected=%0d", ev, e);
            end
        end
    endtask

    always @(negedge clk) begin
        #9;
        more_seen = rst ? 1'b0 : mst_more;
        if (!rst) begin
            if (mst_gnt2) observe(EV_GNT);
            if (slv_selr) observe(EV_SEL);
            if (mst_more) observe(EV_MORE);
            if (arb_rdy2) observe(EV_RDY);
        end
    end

    // Consumer master model: reads once per cycle after each generated strobe
    always @(negedge clk) begin
        #5;
        rd_model = more_seen;
    end

    // One transfer; mode 0: early double ready and repeated write, 1: late ready
    task automatic txn(input bit contest, input int mode);
        exp_q.push_back(EV_GNT);
        exp_q.push_back(EV_SEL);
        exp_q.push_back(EV_MORE);
        exp_q.push_back(EV_MORE);
        exp_q.push_back(EV_RDY);

        tick(); mst_req2 = 1; env_req1 = contest; settle();
        chk("R4 req not yet forwarded", arb_req2, 0);
        chk("R1 req1 relay", arb_req1, contest);
        tick(); settle();
        chk("R4 req still held in idle", arb_req2, 0);
        tick(); settle();
        chk("R4 req forwarded", arb_req2, 1);
        if (contest) begin
            arb_gnt1 = 1; settle();
            chk("R1 gnt1 relay", env_gnt1, 1);
            tick(); settle();
            chk("R5 req kept while req1 served", arb_req2, 1);
            chk("R5 no grant yet", mst_gnt2, 0);
            env_req1 = 0; arb_gnt1 = 0; env_rdy1 = 1; settle();
            chk("R1 rdy1 relay", arb_rdy1, 1);
            tick(); env_rdy1 = 0;
        end
        arb_gnt2 = 1; settle();
        chk("R5 grant not same cycle", mst_gnt2, 0);
        tick(); settle();
        chk("R5 grant forwarded", mst_gnt2, 1);
        mst_req2 = 0; mst_selr = 1;
        tick(); settle();
        chk("R3 single grant pulse", mst_gnt2, 0);
        chk("R6 select forwarded", slv_selr, 1);
        mst_selr = 0;
        tick(); settle();
        chk("R6 select single pulse", slv_selr, 0);
        slv_wrt = 1;
        if (mode == 0) slv_rdy2 = 1;
        tick();
        if (mode != 0) slv_wrt = 0;
        settle();
        chk("R7 more first cycle", mst_more, 1);
        chk("R7 fill after write", chan_fill, 32);
        chk("R8 ready held", arb_rdy2, 0);
        tick(); slv_wrt = 0; slv_rdy2 = 0; settle();
        chk("R7 more second cycle", mst_more, 1);
        chk("R9 extra write ignored", chan_fill, 32);
        tick(); settle();
        chk("R7 more ends", mst_more, 0);
        chk("R7 fill after first read", chan_fill, 16);
        chk("R8 ready held during reads", arb_rdy2, 0);
        tick(); settle();
        chk("R7 fill after second read", chan_fill, 0);
        chk("R8 ready held until drain state ends", arb_rdy2, 0);
        tick(); settle();
        if (mode == 0) begin
            chk("R8 ready released", arb_rdy2, 1);
        end else begin
            chk("R8 late ready not yet", arb_rdy2, 0);
            slv_rdy2 = 1;
            tick(); slv_rdy2 = 0; settle();
            chk("R8 late ready forwarded", arb_rdy2, 1);
        end
        arb_gnt2 = 0;
        tick(); settle();
        chk("R3 single ready pulse", arb_rdy2, 0);
        chk("R10 back in idle", mst_more | slv_selr | mst_gnt2 | arb_req2, 0);
        tick(); tick();
        chk("R7 expected events consumed", exp_q.size(), 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick(); settle();
        chk("R2 reset arb_req2", arb_req2, 0);
        chk("R2 reset mst_gnt2", mst_gnt2, 0);
        chk("R2 reset slv_selr", slv_selr, 0);
        chk("R2 reset arb_rdy2", arb_rdy2, 0);
        chk("R2 reset mst_more", mst_more, 0);
        chk("R2 reset fill", chan_fill, 0);
        rst = 0;
        tick();

        txn(1'b0, 0);
        txn(1'b1, 1);

        // Stray read with an empty channel
        rd_force = 1; tick(); rd_force = 0; settle();
        chk("R9 read on empty ignored", chan_fill, 0);
        chk("R9 no strobe from stray read", mst_more, 0);

        // Reset while a request is held
        tick(); mst_req2 = 1;
        tick(); mst_req2 = 0; rst = 1;
        tick(); rst = 0; settle();
        chk("R2 held request cleared", arb_req2, 0);
        tick(); settle();
        chk("R2 no request after reset", arb_req2, 0);
        tick(); settle();
        chk("R2 still idle", arb_req2, 0);

        txn(1'b0, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule